// File: doc/BRIEF.md
# Chained Control-Block DMA Channel

One DMA channel that moves 32-bit words from a source address to a destination address. The work is described by control blocks that sit in memory. Software writes the address of the first block and then sets the run bit. The channel then loads the eight-word block, performs the copy and follows the block's next pointer. A next pointer of zero stops the channel. A pointer back to an earlier block forms a ring, and the ring runs until software stops it.

Each block says whether the source and destination addresses step by 4 after every word or stay fixed. It can also make reads, writes or both wait for one of several peripheral request lines. A flag in the block asks for an interrupt when the block ends. Software can pause the channel, abandon the current block and move to the next one, or reset the channel. It can also read back the current source and destination addresses to work out how far the copy has gone. The channel reaches memory through one master port. Each beat on that port is a request that the slave completes with a one-cycle valid, which may carry an error.

Control block layout (32-byte aligned, word offsets): 0 transfer info, 1 source, 2 destination, 3 length in bytes, 4 ignored, 5 next block, 6 and 7 ignored.

Top module: `cb_dma_channel`

## Requirements
- R1: After reset the control/status word (offset 0x00) reads 0x0000_0010, meaning inactive and paused. The block address (0x04) reads 0 and irq is low.
- R2: Setting status bit 0 (run) while the block address at 0x04 is nonzero makes the channel read the eight words at that address, advancing in steps of 4.
- R3: A block moves length/4 words, each read from the current source and written to the current destination. Info bit 8 makes the source step by 4 after each word and info bit 4 does the same for the destination. An address whose bit is clear stays fixed.
- R4: At the end of a block the next pointer is copied to 0x04. A nonzero pointer loads that block. A zero pointer clears the run bit, so a ring of blocks keeps running.
- R5: When info bit 0 is set, the end of the block sets status bit 2, and irq follows that bit. Writing 1 to bit 2 clears it, and bit 0 of the same write sets the run state.
- R6: Info bit 10 makes each read wait, and info bit 6 makes each write wait, until the request line chosen by info bits 16 upward is high. Status bit 5 is 1 while the channel waits this way.
- R7: Writing 0 to the run bit stops the channel after the word in flight, and status bit 4 then reads 1. Writing 1 resumes the copy where it stopped, with no word lost.
- R8: Writing status bit 30 together with the run bit abandons the words left in the current block and goes to its next pointer, without an interrupt.
- R9: Writing status bit 31 returns every register to its reset value. Bits 30 and 31 always read 0.
- R10: An error response on the memory port sets status bit 8 and clears the run bit. Writing 1 to bit 8 clears the error flag.
- R11: Offsets 0x0C and 0x10 read the current source and destination addresses. Offset 0x1C reads the next pointer of the loaded block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 5 | register byte offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| mem_req | output | 1 | memory request, held until valid |
| mem_we | output | 1 | request is a write |
| mem_addr | output | 32 | word address of the request |
| mem_wdata | output | 32 | write data |
| mem_valid | input | 1 | request completed this cycle |
| mem_err | input | 1 | completion carries an error |
| mem_rdata | input | 32 | read data with mem_valid |
| dreq | input | NREQ | peripheral request lines |
| irq | output | 1 | block-completion interrupt |

## Verification
Some properties hold on every cycle, and assertions check those. A pending memory request keeps its address until it completes. An error response stops the run state. A zero next pointer ends the chain at the end of a block. A paused channel issues no request. A rising irq always comes from a block whose interrupt bit is set.

Other behaviours need whole scenarios, and only the bench shows them. These cover copies with stepping and fixed addresses, a ring that keeps running, and a pause and resume that loses no word. They also cover an abort that skips a stalled block, waiting on a request line, and reset part way through a block. The bench checks them against memory contents and register reads.

// File: rtl/cb_dma_channel.sv
module cb_dma_channel #(
  parameter int NREQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [4:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_valid,
  input  logic            mem_err,
  input  logic [31:0]     mem_rdata,
  input  logic [NREQ-1:0] dreq,
  output logic            irq
);
  localparam int SELW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int CBW  = 3;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RUN, S_RD, S_WAITW, S_WR} st_t;

  st_t             st;
  logic            active, int_f, err_f, abort_p;
  logic [31:0]     cb_addr, src, dst, len, nxt, data;
  logic [CBW-1:0]  fidx;
  logic            i_int, i_sinc, i_dinc, i_space, i_dpace;
  logic [SELW-1:0] i_sel;

  wire cs_wr    = reg_wr && reg_addr == 5'h00;
  wire cb_wr    = reg_wr && reg_addr == 5'h04;
  wire soft_rst = cs_wr && reg_wdata[31];
  wire req_ok   = dreq[i_sel];
  wire block_end = abort_p || len == 32'd0;

  wire held   = active && ((st == S_RUN && !block_end && i_space && !req_ok) ||
                           (st == S_WAITW && i_dpace && !req_ok));
  wire paused = !active && (st == S_IDLE || st == S_RUN);
  wire [31:0] cs = {23'd0, err_f, 2'b00, held, paused, 1'b0, int_f, 1'b0, active};

  assign mem_req   = st == S_FETCH || st == S_RD || st == S_WR;
  assign mem_we    = st == S_WR;
  assign mem_addr  = (st == S_FETCH) ? {cb_addr[31:5], fidx, 2'b00} :
                     (st == S_RD)    ? src : dst;
  assign mem_wdata = data;
  assign irq       = int_f;

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = cs;
      5'h04:   reg_rdata = cb_addr;
      5'h0C:   reg_rdata = src;
      5'h10:   reg_rdata = dst;
      5'h1C:   reg_rdata = nxt;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      st <= S_IDLE; active <= 1'b0; int_f <= 1'b0; err_f <= 1'b0; abort_p <= 1'b0;
      cb_addr <= '0; src <= '0; dst <= '0; len <= '0; nxt <= '0; data <= '0; fidx <= '0;
      i_int <= 1'b0; i_sinc <= 1'b0; i_dinc <= 1'b0; i_space <= 1'b0; i_dpace <= 1'b0;
      i_sel <= '0;
    end else begin
      if (cs_wr) begin
        active <= reg_wdata[0];
        if (reg_wdata[2])  int_f   <= 1'b0;
        if (reg_wdata[8])  err_f   <= 1'b0;
        if (reg_wdata[30]) abort_p <= 1'b1;
      end
      if (cb_wr) cb_addr <= reg_wdata;
      case (st)
        S_IDLE: begin
          abort_p <= 1'b0;
          if (active) begin
            if (cb_addr == 32'd0) active <= 1'b0;
            else begin st <= S_FETCH; fidx <= '0; end
          end
        end
        S_FETCH: if (mem_valid) begin
          if (mem_err) begin
            err_f <= 1'b1; active <= 1'b0; st <= S_IDLE;
          end else begin
            case (fidx)
              3'd0: begin
                i_int <= mem_rdata[0]; i_dinc <= mem_rdata[4]; i_dpace <= mem_rdata[6];
                i_sinc <= mem_rdata[8]; i_space <= mem_rdata[10];
                i_sel <= mem_rdata[16 +: SELW];
              end
              3'd1: src <= mem_rdata;
              3'd2: dst <= mem_rdata;
              3'd3: len <= {mem_rdata[31:2], 2'b00};
              3'd5: nxt <= mem_rdata;
              default: ;
            endcase
            fidx <= fidx + 1'b1;
            if (fidx == 3'd7) st <= S_RUN;
          end
        end
        S_RUN: if (active) begin
          if (block_end) begin
            if (!abort_p && i_int) int_f <= 1'b1;
            abort_p <= 1'b0;
            cb_addr <= nxt;
            if (nxt == 32'd0) begin active <= 1'b0; st <= S_IDLE; end
            else begin st <= S_FETCH; fidx <= '0; end
          end else if (!i_space || req_ok) st <= S_RD;
        end
        S_RD: if (mem_valid) begin
          if (mem_err) begin
            err_f <= 1'b1; active <= 1'b0; st <= S_IDLE;
          end else begin
            data <= mem_rdata;
            if (i_sinc) src <= src + 32'd4;
            st <= S_WAITW;
          end
        end
        S_WAITW: if (!i_dpace || req_ok) st <= S_WR;
        S_WR: if (mem_valid) begin
          if (mem_err) begin
            err_f <= 1'b1; active <= 1'b0; st <= S_IDLE;
          end else begin
            if (i_dinc) dst <= dst + 32'd4;
            len <= len - 32'd4;
            st <= S_RUN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    mem_req && mem_valid && mem_err && !reg_wr |=> !active && err_f); // R10
  AST_CHAIN_END: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    st == S_RUN && active && len == 32'd0 && !abort_p && nxt == 32'd0 && !reg_wr
    |=> !active && st == S_IDLE); // R4
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    st == S_RUN && !active && !reg_wr |=> !mem_req); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(irq) |-> $past(st == S_RUN && i_int && !abort_p)); // R5
endmodule

// File: tb/cb_dma_channel_tb.sv
module cb_dma_channel_tb;
  localparam int NREQ = 16;
  localparam logic [31:0] F_INT = 32'h1, F_DINC = 32'h10, F_DPACE = 32'h40,
                          F_SINC = 32'h100, F_SPACE = 32'h400;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [4:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata;
  logic mem_valid = 0, mem_err = 0; logic [31:0] mem_rdata = 0;
  logic [NREQ-1:0] dreq = 0;
  logic irq;

  cb_dma_channel #(.NREQ(NREQ)) u_dut (.*);

  always #5 clk = ~clk;

  logic [31:0] mem [0:1023];
  int wcnt [0:1023];
  int rcnt [0:1023];
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  int errors = 0, checks = 0, cycles = 0;

  always @(negedge clk) begin
    if (mem_valid) begin mem_valid = 0; mem_err = 0; end
    else if (mem_req && ($urandom % 3 != 0)) begin
      mem_valid = 1;
      if (mem_addr == err_addr) mem_err = 1;
      else if (mem_we) begin mem[mem_addr[11:2]] = mem_wdata; wcnt[mem_addr[11:2]]++; end
      else begin mem_rdata = mem[mem_addr[11:2]]; rcnt[mem_addr[11:2]]++; end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put_cb(input logic [31:0] b, input logic [31:0] info, input logic [31:0] s,
                        input logic [31:0] d, input int nw, input logic [31:0] nx);
    mem[b[11:2]] = info; mem[b[11:2]+1] = s; mem[b[11:2]+2] = d;
    mem[b[11:2]+3] = 32'(nw * 4); mem[b[11:2]+4] = 32'hDEAD; mem[b[11:2]+5] = nx;
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 1024; i++) begin wcnt[i] = 0; rcnt[i] = 0; end
  endtask

  task automatic wait_stop(input string tag);
    logic [31:0] v; int n = 0;
    do begin rd(5'h00, v); n++; end while (v[0] && n < 5000);
    check(!v[0], tag, v, 32'h0);
  endtask

  function automatic logic [31:0] end_addr(input logic [31:0] base, input int nw, input bit inc);
    return inc ? base + 32'(4 * nw) : base;
  endfunction

  initial begin
    while (1) begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v, a, b, srcb, dstb;
    int nw, bad, seed;
    bit ie;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    clear_counts();
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'h00, v); check(v == 32'h10, "R1 status after reset", v, 32'h10);
    rd(5'h04, v); check(v == 0, "R1 block address after reset", v, 0);
    check(irq == 0, "R1 irq after reset", {31'd0, irq}, 0);

    for (int it = 0; it < 8; it++) begin
      srcb = 32'h400 + 32'(4 * ($urandom % 32));
      dstb = 32'h800 + 32'(4 * ($urandom % 32));
      nw = 1 + $urandom % 24;
      ie = $urandom % 2;
      for (int k = 0; k < nw; k++) mem[srcb[11:2] + k] = $urandom;
      for (int k = 0; k <= nw; k++) mem[dstb[11:2] + k] = 0;
      clear_counts();
      put_cb(32'h40, F_SINC | F_DINC | (ie ? F_INT : 0), srcb, dstb, nw, 0);
      wr(5'h04, 32'h40); wr(5'h00, 32'h1);
      wait_stop("R4 single block stops at zero next");
      if (it == 0) begin
        bad = 0;
        for (int k = 0; k < 8; k++) if (rcnt[16 + k] != 1) bad++;
        check(bad == 0, "R2 eight control-block words fetched", bad, 0);
      end
      bad = 0;
      for (int k = 0; k < nw; k++) if (mem[dstb[11:2] + k] != mem[srcb[11:2] + k]) bad++;
      check(bad == 0, "R3 copied words", bad, 0);
      check(mem[dstb[11:2] + nw] == 0, "R3 word past end untouched", mem[dstb[11:2] + nw], 0);
      rd(5'h0C, v); check(v == end_addr(srcb, nw, 1), "R11 source position", v, end_addr(srcb, nw, 1));
      rd(5'h10, v); check(v == end_addr(dstb, nw, 1), "R11 dest position", v, end_addr(dstb, nw, 1));
      rd(5'h04, v); check(v == 0, "R4 block address takes zero next", v, 0);
      check(irq == ie, "R5 irq follows info bit 0", {31'd0, irq}, {31'd0, ie});
      wr(5'h00, 32'h4);
      check(irq == 0, "R5 write one clears interrupt", {31'd0, irq}, 0);
    end

    mem[32'h300 >> 2] = 32'hCAFE_0001;
    for (int k = 0; k < 5; k++) mem[(32'h900 >> 2) + k] = 0;
    put_cb(32'h40, F_DINC, 32'h300, 32'h900, 4, 0);
    wr(5'h04, 32'h40); wr(5'h00, 32'h1); wait_stop("R3 fixed source run");
    bad = 0;
    for (int k = 0; k < 4; k++) if (mem[(32'h900 >> 2) + k] != 32'hCAFE_0001) bad++;
    check(bad == 0, "R3 fixed source repeats one word", bad, 0);
    rd(5'h0C, v); check(v == end_addr(32'h300, 4, 0), "R3 fixed source address", v, 32'h300);
    clear_counts();
    for (int k = 0; k < 3; k++) mem[(32'h500 >> 2) + k] = 32'h100 + k;
    put_cb(32'h40, F_SINC, 32'h500, 32'h380, 3, 0);
    wr(5'h04, 32'h40); wr(5'h00, 32'h1); wait_stop("R3 fixed dest run");
    check(wcnt[32'h380 >> 2] == 3, "R3 fixed dest write count", wcnt[32'h380 >> 2], 3);
    check(mem[32'h380 >> 2] == 32'h102, "R3 fixed dest last word", mem[32'h380 >> 2], 32'h102);

    put_cb(32'h40, F_SINC | F_DINC | F_INT, 32'h400, 32'h800, 2, 32'h60);
    put_cb(32'h60, F_SINC | F_DINC | F_INT, 32'h420, 32'h820, 2, 32'h40);
    wr(5'h04, 32'h40); wr(5'h00, 32'h1);
    nw = 0;
    for (int r = 0; r < 4; r++) begin
      int t = 0;
      while (!irq && t < 2000) begin @(negedge clk); t++; end
      if (irq) nw++;
      wr(5'h00, 32'h5);
    end
    check(nw == 4, "R4 ring keeps raising interrupts", nw, 4);
    rd(5'h00, v); check(v[0] == 1, "R5 clear with run bit keeps running", v, 32'h1);
    wr(5'h00, 32'h0);
    wr(5'h00, 32'h8000_0000);

    for (int k = 0; k < 40; k++) begin mem[(32'h400 >> 2) + k] = 32'hA000 + k; mem[(32'h800 >> 2) + k] = 0; end
    mem[32'h600 >> 2] = 32'hBEEF; mem[32'h700 >> 2] = 0;
    put_cb(32'h40, F_SINC | F_DINC, 32'h400, 32'h800, 40, 32'h60);
    put_cb(32'h60, F_SINC | F_DINC, 32'h600, 32'h700, 1, 0);
    wr(5'h04, 32'h40); wr(5'h00, 32'h1);
    repeat (30) @(negedge clk);
    wr(5'h00, 32'h0);
    repeat (20) @(negedge clk);
    rd(5'h10, a);
    rd(5'h00, v); check(v[4] == 1, "R7 paused bit", v, 32'h10);
    rd(5'h1C, v); check(v == 32'h60, "R11 next pointer readback", v, 32'h60);
    repeat (30) @(negedge clk);
    rd(5'h10, b); check(a == b, "R7 no progress while paused", b, a);
    wr(5'h00, 32'h1); wait_stop("R7 resume completes");
    bad = 0;
    for (int k = 0; k < 40; k++) if (mem[(32'h800 >> 2) + k] != 32'hA000 + k) bad++;
    check(bad == 0, "R7 no word lost across pause", bad, 0);
    check(mem[32'h700 >> 2] == 32'hBEEF, "R4 chained block copied", mem[32'h700 >> 2], 32'hBEEF);

    clear_counts();
    dreq = 0;
    mem[32'h640 >> 2] = 32'h1111; mem[32'h644 >> 2] = 32'h2222;
    put_cb(32'h40, F_SINC | F_DINC | F_SPACE | F_INT | (32'd3 << 16), 32'h400, 32'hA00, 8, 32'h60);
    put_cb(32'h60, F_SINC | F_DINC, 32'h640, 32'hB00, 2, 0);
    wr(5'h04, 32'h40); wr(5'h00, 32'h1);
    repeat (40) @(negedge clk);
    rd(5'h00, v); check(v[5] == 1, "R6 held bit while read request low", v, 32'h21);
    rd(5'h10, v); check(v == 32'hA00, "R6 no transfer while held", v, 32'hA00);
    wr(5'h00, 32'h4000_0001); wait_stop("R8 abort run");
    check(wcnt[32'hA00 >> 2] == 0, "R8 aborted block wrote nothing", wcnt[32'hA00 >> 2], 0);
    check(mem[32'hB04 >> 2] == 32'h2222, "R8 next block ran", mem[32'hB04 >> 2], 32'h2222);
    check(irq == 0, "R8 abort raises no interrupt", {31'd0, irq}, 0);

    clear_counts();
    mem[32'h400 >> 2] = 32'h5151;
    put_cb(32'h40, F_SINC | F_DINC | F_DPACE | (32'd2 << 16), 32'h400, 32'hC00, 1, 0);
    wr(5'h04, 32'h40); wr(5'h00, 32'h1);
    repeat (40) @(negedge clk);
    rd(5'h00, v); check(v[5] == 1, "R6 held bit while write request low", v, 32'h21);
    check(wcnt[32'hC00 >> 2] == 0, "R6 paced write waits", wcnt[32'hC00 >> 2], 0);
    dreq[2] = 1;
    wait_stop("R6 paced write completes");
    check(mem[32'hC00 >> 2] == 32'h5151, "R6 paced write data", mem[32'hC00 >> 2], 32'h5151);
    dreq = 0;

    err_addr = 32'h408;
    put_cb(32'h40, F_SINC | F_DINC | F_INT, 32'h400, 32'hD00, 3, 32'h60);
    wr(5'h04, 32'h40); wr(5'h00, 32'h1); wait_stop("R10 error stops");
    rd(5'h00, v); check(v[8] == 1 && v[0] == 0, "R10 error flag set, run cleared", v, 32'h110);
    wr(5'h00, 32'h100);
    rd(5'h00, v); check(v[8] == 0, "R10 error flag cleared", v, 32'h10);
    err_addr = 32'hFFFF_FFF0;

    put_cb(32'h40, F_SINC | F_DINC, 32'h400, 32'h800, 40, 32'h60);
    wr(5'h04, 32'h40); wr(5'h00, 32'h1);
    repeat (25) @(negedge clk);
    wr(5'h00, 32'h8000_0000);
    rd(5'h00, v); check(v == 32'h10, "R9 status after soft reset", v, 32'h10);
    rd(5'h04, v); check(v == 0, "R9 block address after soft reset", v, 0);
    rd(5'h1C, v); check(v == 0, "R9 next pointer after soft reset", v, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule